// File: doc/BRIEF.md
# Configurable Look-Up Table Logic Cluster

This block is a cluster of ten small programmable logic elements. Each element computes any Boolean function of its four data inputs through a 16-entry truth table. The result can leave the element directly, or it can pass through a per-element register. That register can behave as a data, toggle, set/reset or J/K flip-flop. From element 2 upward, neighbouring elements are joined by a ripple carry path for arithmetic and by a cascade path. The cascade path merges successive truth-table results with AND or OR to build wide functions.

All elements share one set of cluster controls: a clock enable, a clear, and, in counter mode, a synchronous clear and a synchronous load. Each of the enable and clear controls is taken from one of four global lines, from an input of element 1, or from a fixed value. Whenever element 1's inputs serve as controls, its own table sees zeros. The whole configuration is one vector. It is shifted in one bit per clock while a load strobe is high, and the outputs stay at zero until a full vector has been taken in and the strobe has dropped.

Top module: `lut_cluster`

## Requirements
- R1: Configuration is a CFG_W-bit vector (227 bits by default) shifted in on `cfg_din`, first bit ending at the top, once per clock while `cfg_en` is high. Element e (0-based, element 1 is e=0) owns bits [22e+21:22e]: [15:0] truth table, [17:16] register kind, [18] registered output, [19] arithmetic mode, [20] cascade join, [21] cascade uses OR. Cluster bits at [226:220]: [222:220] enable select, [225:223] clear select, [226] counter mode. `cfg_din` has no effect while `cfg_en` is low.
- R2: `dout` is all zero while `cfg_en` is high and, after reset, until CFG_W bits have been shifted in. Element registers reset to 0 and hold while the cluster is not ready.
- R3: An element with bit 18 clear drives its output directly with table bit number {in3,in2,in1,in0}, in the same cycle as its inputs.
- R4: With bit 18 set, the output is the register, updated on the clock edge when enabled. Let A be the table result and B be raw input 3. Kind 0 loads A. Kind 1 toggles when A is 1. Kind 2 is J/K with J=A, K=B. Kind 3 sets on A alone, clears on B alone, and holds when both or neither are high.
- R5: Enable select codes 0 to 3 pick global line 0 to 3, code 4 picks element 1 input 0, and codes 5 to 7 mean always enabled; a register with enable low keeps its value.
- R6: Clear select codes 0 to 3 pick a global line, code 4 picks element 1 input 1, and codes 5 to 7 mean no clear. While clear is high, registered outputs read 0 at once, and the registers are 0 after the next edge whatever the enable or counter controls say.
- R7: In counter mode, element 1 input 2 is a synchronous clear and input 3 a synchronous load, acting on every register when enabled; the synchronous clear wins over load, and load puts each element's own raw input 3 into its register.
- R8: When the enable select or clear select is 4, or counter mode is on, element 1's table is indexed with 0 instead of its inputs.
- R9: In arithmetic mode, table bits [7:0] indexed by {carry-in,in1,in0} give the result and bits [15:8] with the same index give the carry-out. Element 2 gets carry-in 0. Each later element gets its predecessor's carry-out. Element 1 always gets 0 and its carry goes nowhere.
- R10: For elements 3 to 10 with bit 20 set, the result is the own table result combined with the previous element's result using OR (bit 21 set) or AND; bit 20 has no effect on elements 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_din | input | 1 | Serial configuration bit |
| glb | input | 4 | Global control lines |
| din | input | 40 | Element inputs, four per element, element e at [4e+3:4e] |
| dout | output | 10 | Element outputs, bit e for element e |

## Verification
The assertions take for granted that `glb`, `din`, `cfg_en` and `cfg_din` are synchronous to `clk` and stable around its rising edge. They also assume that a clear, enable or counter-mode control seen at an edge is the one the registers act on, since every such control is built combinationally from those inputs. The stimulus changes all inputs only on the falling edge and keeps `cfg_en` low during every functional run, so configuration and datapath activity never overlap except where the loading rule itself is exercised.

// File: rtl/lutc_pkg.sv
package lutc_pkg;

    localparam int LUT_IN    = 4;
    localparam int LUT_SIZE  = 1 << LUT_IN;
    localparam int SEL_W     = 3;
    localparam int NUM_GLB   = 4;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    // Per-element configuration word; the table sits in the low bits.
    typedef struct packed {
        logic                casc_or;
        logic                casc_en;
        logic                arith;
        logic                reg_en;
        ff_kind_e            kind;
        logic [LUT_SIZE-1:0] table_bits;
    } elem_cfg_t;

    localparam int ELEM_CFG_W = $bits(elem_cfg_t);

    // Cluster-wide configuration word.
    typedef struct packed {
        logic             cnt_mode;
        logic [SEL_W-1:0] clr_sel;
        logic [SEL_W-1:0] ena_sel;
    } clu_cfg_t;

    localparam int CLU_CFG_W = $bits(clu_cfg_t);

    // Resolved cluster controls.
    typedef struct packed {
        logic en;
        logic clr;
        logic sclr;
        logic sload;
        logic redirect;
    } ctl_t;

    // Next register value for a given flip-flop kind.
    function automatic logic ff_next(ff_kind_e kind, logic q, logic a, logic b);
        logic r;
        unique case (kind)
            FF_D:  r = a;
            FF_T:  r = q ^ a;
            FF_JK: r = (a & ~q) | (~b & q);
            FF_SR: begin
                if (a && !b)      r = 1'b1;
                else if (b && !a) r = 1'b0;
                else              r = q;
            end
            default: r = q;
        endcase
        return r;
    endfunction

    // Select one control from global lines, a local pin or a fixed value.
    function automatic logic pick_src(logic [SEL_W-1:0] sel, logic [NUM_GLB-1:0] lines,
                                      logic local_pin, logic fixed_val);
        logic r;
        r = fixed_val;
        for (int g = 0; g < NUM_GLB; g++) begin
            if (sel == SEL_W'(g)) r = lines[g];
        end
        if (sel == SEL_W'(NUM_GLB)) r = local_pin;
        return r;
    endfunction

endpackage

// File: rtl/lutc_cfg_chain.sv
module lutc_cfg_chain #(
    parameter int CFG_W = 227
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic [CFG_W-1:0] cfg_bits,
    output logic             ready
);
    localparam int CNT_W = $clog2(CFG_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

    logic [CNT_W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_bits <= '0;
            shifted  <= '0;
        end else if (cfg_en) begin
            cfg_bits <= {cfg_bits[CFG_W-2:0], cfg_din};
            if (shifted != CNT_FULL) shifted <= shifted + 1'b1;
        end
    end

    // Usable once a full vector has arrived and the strobe is released.
    assign ready = (shifted == CNT_FULL) && !cfg_en;

endmodule

// File: rtl/lutc_ctrl.sv
module lutc_ctrl
    import lutc_pkg::*;
(
    input  clu_cfg_t            cfg,
    input  logic [NUM_GLB-1:0]  glb,
    input  logic [LUT_IN-1:0]   e1_in,
    output ctl_t                ctl
);
    localparam logic [SEL_W-1:0] SEL_LOCAL = SEL_W'(NUM_GLB);

    always_comb begin
        ctl.en       = pick_src(cfg.ena_sel, glb, e1_in[0], 1'b1);
        ctl.clr      = pick_src(cfg.clr_sel, glb, e1_in[1], 1'b0);
        ctl.sclr     = cfg.cnt_mode && e1_in[2];
        ctl.sload    = cfg.cnt_mode && e1_in[3];
        ctl.redirect = (cfg.ena_sel == SEL_LOCAL) || (cfg.clr_sel == SEL_LOCAL)
                       || cfg.cnt_mode;
    end

endmodule

// File: rtl/lutc_lut.sv
module lutc_lut
    import lutc_pkg::*;
(
    input  elem_cfg_t          cfg,
    input  logic [LUT_IN-1:0]  lin,
    input  logic               cin,
    input  logic               casc_in,
    input  logic               casc_ok,
    output logic               y,
    output logic               cout
);
    logic [LUT_IN-2:0] aidx;
    logic              base;

    always_comb begin
        aidx = {cin, lin[1:0]};
        if (cfg.arith) begin
            base = cfg.table_bits[{1'b0, aidx}];
            cout = cfg.table_bits[{1'b1, aidx}];
        end else begin
            base = cfg.table_bits[lin];
            cout = 1'b0;
        end
        if (casc_ok && cfg.casc_en)
            y = cfg.casc_or ? (base | casc_in) : (base & casc_in);
        else
            y = base;
    end

endmodule

// File: rtl/lutc_ff.sv
module lutc_ff
    import lutc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ready,
    input  ff_kind_e kind,
    input  logic     en,
    input  logic     clr,
    input  logic     sclr,
    input  logic     sload,
    input  logic     a_in,
    input  logic     aux,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ready) begin
            if (clr)        q <= 1'b0;
            else if (en) begin
                if (sclr)       q <= 1'b0;
                else if (sload) q <= aux;
                else             q <= ff_next(kind, q, a_in, aux);
            end
        end
    end

endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lutc_pkg::*;
#(
    parameter int NUM_ELEM = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_en,
    input  logic                       cfg_din,
    input  logic [NUM_GLB-1:0]         glb,
    input  logic [NUM_ELEM*LUT_IN-1:0] din,
    output logic [NUM_ELEM-1:0]        dout
);
    localparam int CFG_W    = NUM_ELEM * ELEM_CFG_W + CLU_CFG_W;
    localparam int CLU_BASE = NUM_ELEM * ELEM_CFG_W;
    localparam int CHAIN_LO = 1;

    logic [CFG_W-1:0]    cfg_bits;
    logic                ready;
    clu_cfg_t            clu;
    ctl_t                ctl;
    logic [NUM_ELEM-1:0] y_v, cout_v, cin_v, cas_in_v, cas_ok_v, q_all;

    lutc_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_bits (cfg_bits),
        .ready    (ready)
    );

    assign clu = clu_cfg_t'(cfg_bits[CLU_BASE +: CLU_CFG_W]);

    lutc_ctrl u_ctrl (
        .cfg   (clu),
        .glb   (glb),
        .e1_in (din[LUT_IN-1:0]),
        .ctl   (ctl)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_el
        elem_cfg_t         ec;
        logic [LUT_IN-1:0] raw, lin;

        assign ec  = elem_cfg_t'(cfg_bits[e*ELEM_CFG_W +: ELEM_CFG_W]);
        assign raw = din[e*LUT_IN +: LUT_IN];

        if (e == 0) begin : g_head
            // Element 1 inputs may be taken over as cluster controls.
            assign lin = ctl.redirect ? '0 : raw;
        end else begin : g_body
            assign lin = raw;
        end

        if (e <= CHAIN_LO) begin : g_chain_edge
            assign cin_v[e]    = 1'b0;
            assign cas_in_v[e] = 1'b0;
            assign cas_ok_v[e] = 1'b0;
        end else begin : g_chain_link
            assign cin_v[e]    = cout_v[e-1];
            assign cas_in_v[e] = y_v[e-1];
            assign cas_ok_v[e] = 1'b1;
        end

        lutc_lut u_lut (
            .cfg     (ec),
            .lin     (lin),
            .cin     (cin_v[e]),
            .casc_in (cas_in_v[e]),
            .casc_ok (cas_ok_v[e]),
            .y       (y_v[e]),
            .cout    (cout_v[e])
        );

        lutc_ff u_ff (
            .clk   (clk),
            .rst   (rst),
            .ready (ready),
            .kind  (ec.kind),
            .en    (ctl.en),
            .clr   (ctl.clr),
            .sclr  (ctl.sclr),
            .sload (ctl.sload),
            .a_in  (y_v[e]),
            .aux   (raw[LUT_IN-1]),
            .q     (q_all[e])
        );

        assign dout[e] = ready && (ec.reg_en ? (q_all[e] && !ctl.clr) : y_v[e]);
    end

endmodule

// File: rtl/lutc_cluster_chk.sv
module lutc_cluster_chk
    import lutc_pkg::*;
#(
    parameter int NUM_ELEM = 10,
    parameter int CFG_W    = 227
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_en,
    input logic                ready,
    input clu_cfg_t            clu,
    input ctl_t                ctl,
    input logic [CFG_W-1:0]    cfg_bits,
    input logic [NUM_ELEM-1:0] q_all,
    input logic [NUM_ELEM-1:0] dout
);
    // R1: configuration only moves under the strobe.
    a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_bits));

    // R2: outputs blank during loading.
    a_r2_blank_load: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> dout == '0);

    // R2: registers frozen while not ready.
    a_r2_hold_unready: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(q_all));

    // R5: disabled registers keep their state.
    a_r5_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (ready && !ctl.clr && !ctl.en) |=> $stable(q_all));

    // R6: clear empties every register.
    a_r6_clear_wipes: assert property (@(posedge clk) disable iff (rst)
        (ready && ctl.clr) |=> q_all == '0);

    // R7: synchronous clear wins in counter mode.
    a_r7_sclr_wins: assert property (@(posedge clk) disable iff (rst)
        (ready && !ctl.clr && ctl.en && clu.cnt_mode && ctl.sclr) |=> q_all == '0);

endmodule

bind lut_cluster lutc_cluster_chk #(.NUM_ELEM(NUM_ELEM), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .ready    (ready),
    .clu      (clu),
    .ctl      (ctl),
    .cfg_bits (cfg_bits),
    .q_all    (q_all),
    .dout     (dout)
);

// File: tb/lut_cluster_test.sv
`timescale 1ns/1ps
module lut_cluster_test;
    localparam int NE = 10;
    localparam int LI = 4;
    localparam int NG = 4;
    localparam int EW = 22;
    localparam int CW = NE * EW + 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [NG-1:0] glb = '0;
    logic [NE*LI-1:0] din = '0;
    logic [NE-1:0] dout;

    lut_cluster #(.NUM_ELEM(NE)) uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .glb(glb), .din(din), .dout(dout)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [CW-1:0] cfg_v;
    logic [NE-1:0] q_m, y_m, last;
    logic m_en, m_clr, m_sclr, m_sload, m_cnt, m_redir;
    logic [31:0] seed = 32'h2468_ace1;

    function logic [31:0] next_rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input string req, input logic [NE-1:0] act, input logic [NE-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_elem(input int e, input logic [15:0] tbl, input logic [1:0] kind,
                            input bit rg, input bit ar, input bit ce, input bit co);
        cfg_v[e*EW +: EW] = {co, ce, ar, rg, kind, tbl};
    endtask

    task automatic set_clu(input logic [2:0] ena, input logic [2:0] clr, input bit cnt);
        cfg_v[NE*EW +: 7] = {cnt, clr, ena};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q_m = '0;
    endtask

    task automatic load_cfg();
        do_reset();
        cfg_en = 1'b1;
        for (int b = CW - 1; b >= 0; b--) begin
            cfg_din = cfg_v[b];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    task automatic model(input logic [NE*LI-1:0] d, input logic [NG-1:0] g);
        logic [3:0] idx;
        logic [15:0] lt;
        logic [2:0] es, cs;
        logic cprev, cin, base, cout;
        es = cfg_v[NE*EW +: 3];
        cs = cfg_v[NE*EW+3 +: 3];
        m_cnt = cfg_v[NE*EW+6];
        m_en  = (es < 3'd4) ? g[es[1:0]] : ((es == 3'd4) ? d[0] : 1'b1);
        m_clr = (cs < 3'd4) ? g[cs[1:0]] : ((cs == 3'd4) ? d[1] : 1'b0);
        m_sclr = d[2];
        m_sload = d[3];
        m_redir = (es == 3'd4) || (cs == 3'd4) || m_cnt;
        cprev = 1'b0;
        for (int e = 0; e < NE; e++) begin
            idx = d[e*LI +: LI];
            if (e == 0 && m_redir) idx = '0;
            lt = cfg_v[e*EW +: 16];
            cin = (e >= 2) ? cprev : 1'b0;
            if (cfg_v[e*EW+19]) begin
                base = lt[{1'b0, cin, idx[1:0]}];
                cout = lt[{1'b1, cin, idx[1:0]}];
            end else begin
                base = lt[idx];
                cout = 1'b0;
            end
            if (e >= 2 && cfg_v[e*EW+20])
                base = cfg_v[e*EW+21] ? (base | y_m[e-1]) : (base & y_m[e-1]);
            y_m[e] = base;
            cprev = cout;
        end
    endtask

    function automatic logic [NE-1:0] exp_out();
        logic [NE-1:0] r;
        for (int e = 0; e < NE; e++)
            r[e] = cfg_v[e*EW+18] ? (m_clr ? 1'b0 : q_m[e]) : y_m[e];
        return r;
    endfunction

    task automatic advance(input logic [NE*LI-1:0] d);
        logic a, b, q;
        logic [1:0] k;
        for (int e = 0; e < NE; e++) begin
            a = y_m[e];
            b = d[e*LI+3];
            q = q_m[e];
            k = cfg_v[e*EW+16 +: 2];
            if (m_clr) q = 1'b0;
            else if (m_en) begin
                if (m_cnt && m_sclr) q = 1'b0;
                else if (m_cnt && m_sload) q = b;
                else begin
                    case (k)
                        2'd0: q = a;
                        2'd1: q = q ^ a;
                        2'd2: q = a ? (b ? ~q : 1'b1) : (b ? 1'b0 : q);
                        default: q = (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
                    endcase
                end
            end
            q_m[e] = q;
        end
    endtask

    task automatic step(input logic [NE*LI-1:0] d, input logic [NG-1:0] g, input string req);
        logic [31:0] r;
        r = next_rnd();
        din = d;
        glb = g;
        cfg_din = r[0];
        #1;
        model(d, g);
        last = dout;
        check(req, dout, exp_out());
        advance(d);
        @(negedge clk);
    endtask

    function automatic logic [NE*LI-1:0] rnd_din();
        logic [63:0] v;
        v = {next_rnd(), next_rnd()};
        return v[NE*LI-1:0];
    endfunction

    task automatic run_random(input int n, input string req);
        logic [31:0] r;
        logic [NG-1:0] g;
        for (int i = 0; i < n; i++) begin
            r = next_rnd();
            g = r[NG-1:0];
            g[1] = (r[7:5] == 3'd0);
            g[3] = (r[10:8] == 3'd0);
            step(rnd_din(), g, req);
        end
    endtask

    initial begin : main
        logic [NE*LI-1:0] d;
        logic [8:0] s;
        int bb;
        cfg_v = '0;
        do_reset();
        // R2: nothing configured yet
        din = rnd_din();
        #1;
        check("R2 blank after reset", dout, '0);
        @(negedge clk);
        // R2: incomplete vector
        cfg_en = 1'b1;
        for (int i = 0; i < 100; i++) begin
            cfg_din = 1'b1;
            @(negedge clk);
        end
        cfg_en = 1'b0;
        din = {NE*LI{1'b1}};
        #1;
        check("R2 blank after partial load", dout, '0);
        @(negedge clk);

        // R3: plain table lookup
        for (int e = 0; e < NE; e++) set_elem(e, next_rnd() | 16'h0001, 2'd0, 0, 0, 0, 0);
        set_clu(3'd7, 3'd7, 0);
        load_cfg();
        for (int n = 0; n < 256; n++) begin
            for (int e = 0; e < NE; e++) d[e*LI +: LI] = 4'(n + e * 3 + (n >> 4));
            step(d, 4'hF, "R3 table lookup");
        end
        // R1: serial input toggles with strobe low
        d = rnd_din();
        for (int i = 0; i < 32; i++) step(d, '0, "R1 serial input ignored");
        // R2: strobe raised again blanks outputs
        cfg_en = 1'b1;
        din = {NE*LI{1'b1}};
        @(negedge clk);
        #1;
        check("R2 blank while loading", dout, '0);
        @(negedge clk);
        cfg_en = 1'b0;

        // R10: cascade joins, elements 1 and 2 ignore the join bit
        for (int e = 0; e < NE; e++) set_elem(e, next_rnd(), 2'd0, 0, 0, 1, e % 2);
        set_clu(3'd7, 3'd7, 0);
        load_cfg();
        for (int i = 0; i < 300; i++) step(rnd_din(), '0, "R10 cascade");

        // R9: 8-bit adder on elements 2..9, carry out on element 10
        set_elem(0, 16'hFF00, 2'd0, 0, 1, 0, 0);
        for (int e = 1; e <= 8; e++) set_elem(e, 16'hE896, 2'd0, 0, 1, 0, 0);
        set_elem(9, 16'h00F0, 2'd0, 0, 1, 0, 0);
        set_clu(3'd7, 3'd7, 0);
        load_cfg();
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                bb = (k == 15) ? 255 : ((a * 37 + k * 51) & 255);
                d = '0;
                d[3:0] = 4'(a + k);
                for (int e = 1; e <= 8; e++) begin
                    d[e*LI]   = a[e-1];
                    d[e*LI+1] = bb[e-1];
                end
                step(d, '0, "R9 adder model");
                s = 9'(a + bb);
                check("R9 adder sum, element one outside chain", last, {s, 1'b0});
            end
        end

        // R4 R5 R6: register kinds, enable glb0, clear glb1
        for (int e = 0; e < NE; e++) set_elem(e, 16'hAAAA, 2'(e % 4), 1, 0, 0, 0);
        set_clu(3'd0, 3'd1, 0);
        load_cfg();
        run_random(400, "R4 register kinds, R6 clear");
        set_clu(3'd2, 3'd3, 0);
        load_cfg();
        run_random(300, "R5 enable glb2, R6 clear glb3");
        set_clu(3'd6, 3'd7, 0);
        load_cfg();
        run_random(200, "R5 always enabled");

        // R7 R8: counter mode, enable from element 1 input 0
        set_elem(0, 16'hFFFE, 2'd0, 1, 0, 0, 0);
        for (int e = 1; e < NE; e++) set_elem(e, 16'hAAAA, 2'(e % 4), 1, 0, 0, 0);
        set_clu(3'd4, 3'd7, 1);
        load_cfg();
        run_random(400, "R7 counter clear/load, R8 redirect");

        // R8 R6: clear from element 1 input 1, element 1 combinational
        set_elem(0, 16'hFFFE, 2'd0, 0, 0, 0, 0);
        for (int e = 1; e < NE; e++) set_elem(e, 16'hAAAA, 2'd1, 1, 0, 0, 0);
        set_clu(3'd7, 3'd4, 0);
        load_cfg();
        run_random(300, "R8 element one table sees zero, R6 local clear");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule